// File: doc/BRIEF.md
# Conditional Relative Jump Unit

This block resolves one jump instruction word per evaluation. It recognises the jump format by the three top bits of the 16-bit instruction word. It tests the 3-bit condition field against the negative, zero, carry and overflow flags. When the condition is met, it forms the branch target from a 10-bit signed word offset. Otherwise it hands back the sequential program counter. Decision and target are combinational.

A registered program counter copy, `pc_q`, loads the chosen next address on a rising clock edge when `step_en` is high. An odd input program counter is illegal because instructions always sit on even byte addresses. In that case the block raises `align_err`, and the registered copy refuses to load.

Top module: `jump_unit`

## Requirements
- R1: The word is a jump when bits 15:13 equal 3'b001. Bits 12:10 select the condition: 0 taken when Z=0, 1 when Z=1, 2 when C=0, 3 when C=1, 4 when N=1, 5 when N equals V, 6 when N differs from V, 7 always. `taken` is high exactly when the word is a jump and its condition holds.
- R2: On a taken jump, `next_pc` = `pc_in` + 2 + 2 × (bits 9:0 read as two's complement), modulo 2^16. The reachable span is −511 to +512 words from the jump.
- R3: On a not-taken jump, `next_pc` = `pc_in` + 2, modulo 2^16.
- R4: A word whose bits 15:13 are not 3'b001 is never taken, and `next_pc` = `pc_in` + 2, whatever the flags.
- R5: `align_err` equals bit 0 of `pc_in`.
- R6: `pc_q` is 0 after reset. On a rising edge with `step_en` high and `align_err` low, it takes `next_pc`. Otherwise it keeps its value.
- R7: The fixed encodings decode as follows. 0x2FE4 at 0x8000 with C=1 goes to 0x7FCA. 0x23FD at 0x8026 with Z=0 goes to 0x8022. 0x3FF3 at 0x802A goes to 0x8012.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_en | input | 1 | Load `next_pc` into `pc_q` on this edge |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | Address of the instruction word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| taken | output | 1 | Jump condition met |
| next_pc | output | 16 | Address of the next instruction |
| align_err | output | 1 | Odd program counter seen |
| pc_q | output | 16 | Registered program counter |

## Verification
Every opcode prefix is swept against every condition code and all sixteen flag combinations. This separates each condition from its complement and confirms that non-jump prefixes never branch. Offsets of 0, ±1, −28 and both field extremes are used at a low, a mid and a top-of-range program counter. These values expose sign-extension errors, missing word scaling and wrong wrap-around. The three fixed encodings are checked against known targets. Register steps with the enable low, and with an odd program counter, separate load from hold.

// File: rtl/jump_unit.sv
module jump_unit #(
  parameter int PC_W = 16,
  parameter int OFF_W = 10,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic [15:0]     instr,
  input  logic [PC_W-1:0] pc_in,
  input  logic            flag_n,
  input  logic            flag_z,
  input  logic            flag_c,
  input  logic            flag_v,
  output logic            taken,
  output logic [PC_W-1:0] next_pc,
  output logic            align_err,
  output logic [PC_W-1:0] pc_q
);
  localparam logic [2:0] JMP_PREFIX = 3'b001;
  localparam int EXT_W = PC_W - OFF_W;

  logic            is_jmp;
  logic            cond_ok;
  logic [2:0]      cond;
  logic [PC_W-1:0] seq_pc, byte_off, target;

  assign is_jmp = (instr[15:13] == JMP_PREFIX);
  assign cond   = instr[12:10];

  always_comb begin
    case (cond)
      3'd0: cond_ok = ~flag_z;
      3'd1: cond_ok = flag_z;
      3'd2: cond_ok = ~flag_c;
      3'd3: cond_ok = flag_c;
      3'd4: cond_ok = flag_n;
      3'd5: cond_ok = ~(flag_n ^ flag_v);
      3'd6: cond_ok = flag_n ^ flag_v;
      default: cond_ok = 1'b1;
    endcase
  end

  assign byte_off  = {{(EXT_W-1){instr[OFF_W-1]}}, instr[OFF_W-1:0], 1'b0};
  assign seq_pc    = pc_in + PC_W'(2);
  assign target    = seq_pc + byte_off;
  assign taken     = is_jmp & cond_ok;
  assign next_pc   = taken ? target : seq_pc;
  assign align_err = pc_in[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pc_q <= RESET_PC;
    else if (step_en && !align_err) pc_q <= next_pc;
  end

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc_q));
  assert_hold_misaligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && pc_in[0]) |=> $stable(pc_q));
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !pc_in[0]) |=> (pc_q == $past(next_pc)));
  assert_non_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15:13] != 3'b001) |-> (!taken && next_pc == pc_in + PC_W'(2)));
  assert_always_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15:10] == 6'b001111) |-> taken);
  assert_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> (next_pc == pc_in + PC_W'(2)));
endmodule

// File: tb/test_jump_unit.sv
module test_jump_unit;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, step_en = 1'b0;
  logic [15:0] instr = '0, pc_in = '0;
  logic flag_n = 0, flag_z = 0, flag_c = 0, flag_v = 0;
  logic taken, align_err;
  logic [15:0] next_pc, pc_q;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  jump_unit i_jump_unit (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .instr(instr), .pc_in(pc_in),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .taken(taken), .next_pc(next_pc), .align_err(align_err), .pc_q(pc_q));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_cond(input int c, input bit n, input bit z, input bit cy, input bit v);
    case (c)
      0: return !z;
      1: return z;
      2: return !cy;
      3: return cy;
      4: return n;
      5: return n == v;
      6: return n != v;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int offs[6] = '{0, 1, -1, 511, -512, -28};
    int pcs[3]  = '{16'h0002, 16'h8000, 16'hFFFE};
    #(CLK_P*2);
    chk("R6 reset", pc_q, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 16; f++)
          for (int oi = 0; oi < 6; oi++)
            for (int pi = 0; pi < 3; pi++) begin
              bit tk;
              int e;
              instr = 16'((op << 13) | (c << 10) | (offs[oi] & 16'h3FF));
              pc_in = 16'(pcs[pi]);
              {flag_n, flag_z, flag_c, flag_v} = 4'(f);
              #1;
              tk = (op == 1) && exp_cond(c, f[3], f[2], f[1], f[0]);
              e = tk ? pcs[pi] + 2 + 2 * offs[oi] : pcs[pi] + 2;
              if (op != 1) begin
                chk("R4 taken", 16'(taken), 16'(tk));
                chk("R4 next_pc", next_pc, 16'(e));
              end else if (tk) begin
                chk("R1 taken", 16'(taken), 16'(tk));
                chk("R2 target", next_pc, 16'(e));
              end else begin
                chk("R1 taken", 16'(taken), 16'(tk));
                chk("R3 sequential", next_pc, 16'(e));
              end
              chk("R5 align_err", 16'(align_err), 16'h0000);
            end

    @(negedge clk);
    instr = 16'h2FE4; pc_in = 16'h8000; {flag_n, flag_z, flag_c, flag_v} = 4'b0010;
    #1 chk("R7 carry-set jump", next_pc, 16'h7FCA);
    flag_c = 0;
    #1 chk("R7 carry clear falls through", next_pc, 16'h8002);
    instr = 16'h23FD; pc_in = 16'h8026; flag_z = 0;
    #1 chk("R7 not-equal jump", next_pc, 16'h8022);
    instr = 16'h3FF3; pc_in = 16'h802A;
    #1 chk("R7 unconditional jump", next_pc, 16'h8012);

    step_en = 1'b0;
    @(posedge clk); #1 chk("R6 hold when idle", pc_q, 16'h0000);
    @(negedge clk); step_en = 1'b1;
    @(posedge clk); #1 chk("R6 load", pc_q, 16'h8012);
    @(negedge clk); pc_in = 16'h802B;
    #1 chk("R5 odd pc flagged", 16'(align_err), 16'h0001);
    @(posedge clk); #1 chk("R5 odd pc no load", pc_q, 16'h8012);
    @(negedge clk); pc_in = 16'h0100; instr = 16'h4303;
    @(posedge clk); #1 chk("R4 non-jump load", pc_q, 16'h0102);
    @(negedge clk); step_en = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule